// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Byte-Folding Bus Port

This block is the digital core of a 12-bit successive-approximation analog-to-digital converter. A host starts a conversion by pulling chip select and read low together while the high-byte select is low. The block then runs a fixed bit-trial sequence against an external comparator. It presents the trial code to an external DAC and drives an active-low busy flag for the length of the conversion. At the end of the sequence it latches the decided word, which the host reads back on a 12-pin data port.

The host can read the data port as one full word or as two bytes. When the high-byte select is high, the upper four result bits are folded onto the lowest four pins and the four pins above them are driven low. A read with the high-byte select high never starts a conversion, so a byte-wide host can collect both halves without launching a new sample. The three bus strobes are synchronised to the converter clock before the start edge is detected. The data-port enable and the byte selection follow the strobes directly.

The port has no valid/ready handshake. The host paces itself on the busy flag or on a known conversion time, so the block needs no back-pressure rules.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A conversion starts only on a falling edge of the combined strobe (cs_n and rd_n both low), seen after synchronisation, while hben is low. A read with hben high leaves busy_n high.
- R2: A start clears the approximation register, so trial_code is 0 in the first busy cycle. busy_n is driven low at the same time.
- R3: Bits are tried from MSB (bit 11) to LSB (bit 0), one per clock. The trial for bit 11 is presented in the second busy cycle. Each trial sets the bit under test to 1, and the bit keeps that 1 only if cmp_above is 1 in that cycle. With a comparator that reports input >= trial_code, the result therefore equals the input code.
- R4: busy_n stays low for exactly WIDTH+1 = 13 clock cycles. A new strobe edge during a conversion neither restarts nor stretches it.
- R5: While busy_n is low, the data port keeps showing the previous result. The new result appears when busy_n returns high.
- R6: With hben low and the port enabled, data_out[11:0] equals result bits 11..0.
- R7: With hben high and the port enabled, data_out[11:8] and data_out[3:0] both carry result bits 11..8, and data_out[7:4] is 0.
- R8: data_oe is 1 exactly when cs_n and rd_n are both low.
- R9: After reset, busy_n is 1, trial_code is 0 and the held result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| hben | input | 1 | High-byte select; blocks a conversion start |
| cmp_above | input | 1 | Comparator: analog input is at or above the DAC level |
| trial_code | output | 12 | Code driving the external DAC |
| busy_n | output | 1 | Low while a conversion runs |
| data_oe | output | 1 | Enable for the external tri-state data drivers |
| data_out | output | 12 | Data port: full word or folded high byte |

## Verification
The bench builds the block with its default WIDTH of 12 and BYTE_W of 8. It models the comparator arithmetically as input >= trial_code, so every conversion is expected to return its own input code. These values make a near-exhaustive sweep affordable: every fifth code from 0 to 4095, plus full scale, at about twenty cycles per conversion. The sweep reaches the all-zero, midscale and all-one words, and each conversion also checks the hold of the previous result, the 13-cycle busy window and the MSB-first trial. Separate runs cover high-byte reads that must not start a conversion, the folded byte layout, the data-port enable for each strobe combination, and a strobe re-edge in the middle of a conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;
  // Sequencer phase: idle, one settling cycle, then one cycle per bit trial
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_TRIAL  = 2'd2
  } phase_t;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] trial_code,
  output logic [WIDTH-1:0] decided,
  output logic             busy,
  output logic             done
);
  localparam int BW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [BW-1:0] TOP_BIT = BW'(WIDTH-1);

  phase_t           phase_q;
  logic [BW-1:0]    bitpos_q;
  logic [WIDTH-1:0] sar_q;
  logic [WIDTH-1:0] mask;

  // One-hot mask of the bit under test, only during trial cycles
  always_comb begin
    mask = '0;
    if (phase_q == PH_TRIAL) mask[bitpos_q] = 1'b1;
  end

  assign trial_code = sar_q | mask;
  assign decided    = cmp_above ? (sar_q | mask) : sar_q;
  assign busy       = (phase_q != PH_IDLE);
  assign done       = (phase_q == PH_TRIAL) && (bitpos_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      bitpos_q <= '0;
      sar_q    <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETTLE;
            sar_q   <= '0;
          end
        end
        PH_SETTLE: begin
          phase_q  <= PH_TRIAL;
          bitpos_q <= TOP_BIT;
        end
        PH_TRIAL: begin
          sar_q <= decided;
          if (bitpos_q == '0) phase_q  <= PH_IDLE;
          else                bitpos_q <= bitpos_q - 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_outmux.sv
module sar_outmux #(
  parameter int WIDTH  = 12,
  parameter int BYTE_W = 8
) (
  input  logic [WIDTH-1:0] word,
  input  logic             hi_sel,
  output logic [WIDTH-1:0] pins
);
  localparam int HI_W  = WIDTH - BYTE_W;
  localparam int MID_W = BYTE_W - HI_W;

  logic [WIDTH-1:0] folded;

  // Upper bits stay in place, are copied to the bottom, and the middle is zero
  assign folded = {word[WIDTH-1:BYTE_W], {MID_W{1'b0}}, word[WIDTH-1:BYTE_W]};
  assign pins   = hi_sel ? folded : word;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int WIDTH       = 12,
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             rd_n,
  input  logic             hben,
  input  logic             cmp_above,
  output logic [WIDTH-1:0] trial_code,
  output logic             busy_n,
  output logic             data_oe,
  output logic [WIDTH-1:0] data_out
);
  logic [2:0]       strobes_s;
  logic             strobe_s, strobe_d, hben_s;
  logic             start, busy, done;
  logic [WIDTH-1:0] decided, result_q;

  // Order: {hben, rd_n, cs_n}; strobes idle high, hben idle low
  sar_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hben, rd_n, cs_n}),
    .q     (strobes_s)
  );

  assign strobe_s = ~strobes_s[0] & ~strobes_s[1];
  assign hben_s   = strobes_s[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b0;
    else        strobe_d <= strobe_s;
  end

  // Edges that arrive while busy are dropped (R4)
  assign start = strobe_s & ~strobe_d & ~hben_s & ~busy;

  sar_seq #(.WIDTH(WIDTH)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .cmp_above  (cmp_above),
    .trial_code (trial_code),
    .decided    (decided),
    .busy       (busy),
    .done       (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    result_q <= '0;
    else if (done) result_q <= decided;
  end

  sar_outmux #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_mux (
    .word   (result_q),
    .hi_sel (hben),
    .pins   (data_out)
  );

  assign busy_n  = ~busy;
  assign data_oe = ~cs_n & ~rd_n;
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int WIDTH  = 12,
  parameter int BYTE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hben,
  input logic [WIDTH-1:0] trial_code,
  input logic             busy_n,
  input logic             data_oe,
  input logic [WIDTH-1:0] data_out
);
  localparam int CONV = WIDTH + 1;
  localparam int CW   = $clog2(CONV + 2) + 1;
  localparam int HI_W = WIDTH - BYTE_W;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       low_cnt <= '0;
    else if (!busy_n) low_cnt <= low_cnt + 1'b1;
    else              low_cnt <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_n) |-> low_cnt == CW'(CONV)); // R4

  AST_SAR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |-> trial_code == '0); // R2

  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_n) |=> trial_code == MSB_ONLY); // R3

  AST_HOLD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_n && !$past(busy_n) && data_oe && $past(data_oe) && hben == $past(hben))
      |-> $stable(data_out)); // R5

  AST_FOLD_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_oe && hben) |->
      (data_out[BYTE_W-1:HI_W] == '0) &&
      (data_out[HI_W-1:0] == data_out[WIDTH-1:BYTE_W])); // R7
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.WIDTH(WIDTH), .BYTE_W(BYTE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hben       (hben),
  .trial_code (trial_code),
  .busy_n     (busy_n),
  .data_oe    (data_oe),
  .data_out   (data_out)
);

// File: tb/sar_adc_ctrl_tb.sv
module sar_adc_ctrl_tb;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cs_n = 1'b1, rd_n = 1'b1, hben = 1'b0;
  logic         cmp_above;
  logic [W-1:0] trial_code, data_out;
  logic         busy_n, data_oe;
  int           vin = 0;
  int           prev = 0;
  int           n_run = 0, n_fail = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // Comparator model: input at or above the DAC level
  assign cmp_above = (vin >= int'(trial_code));

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .hben(hben),
    .cmp_above(cmp_above), .trial_code(trial_code), .busy_n(busy_n),
    .data_oe(data_oe), .data_out(data_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One full-word conversion; glitch re-edges the strobe mid-conversion
  task automatic convert(input int v, input bit glitch);
    int n = 0;
    int low = 0;
    vin = v;
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b0;
    #1;
    chk("R8 oe with both strobes low", int'(data_oe), 1);
    while (busy_n && n < 10) begin @(negedge clk); n++; end
    chk("R1 start on strobe edge", int'(busy_n), 0);
    while (!busy_n && low < 40) begin
      if (low == 0) chk("R2 SAR cleared", int'(trial_code), 0);
      if (low == 1) chk("R3 MSB trial first", int'(trial_code), 1 << (W-1));
      if (data_oe) chk("R5 old result held", int'(data_out), prev);
      if (glitch && low == 4) rd_n = 1'b1;
      if (glitch && low == 8) rd_n = 1'b0;
      @(negedge clk);
      low++;
    end
    chk("R4 busy length", low, W + 1);
    #1;
    chk("R6 R3 full word result", int'(data_out), v);
    prev = v;
    cs_n = 1'b1; rd_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 busy_n after reset", int'(busy_n), 1);
    chk("R9 trial_code after reset", int'(trial_code), 0);
    chk("R8 oe idle", int'(data_oe), 0);
    // high-byte read of the reset result: no start, zero word
    cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
    #1;
    chk("R9 reset result", int'(data_out), 0);
    repeat (20) begin
      @(negedge clk);
      chk("R1 hben blocks start", int'(busy_n), 1);
    end
    cs_n = 1'b1; rd_n = 1'b1; hben = 1'b0;
    repeat (3) @(negedge clk);

    // R8: each strobe alone does not enable the port
    cs_n = 1'b0; #1;
    chk("R8 cs only", int'(data_oe), 0);
    cs_n = 1'b1; rd_n = 1'b0; #1;
    chk("R8 rd only", int'(data_oe), 0);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // Near-exhaustive sweep of input codes
    for (int v = 0; v < (1 << W); v += 5) convert(v, 1'b0);
    convert((1 << W) - 1, 1'b0);
    convert(2048, 1'b0);
    convert(2047, 1'b0);

    // R4: strobe re-edge during a conversion is ignored
    convert(1234, 1'b1);
    convert(3001, 1'b1);

    // R7: folded high-byte reads, no conversion started
    for (int v = 0; v < 16; v++) begin
      int code = v * 273;
      int hi;
      convert(code, 1'b0);
      hi = code >> 8;
      cs_n = 1'b0; rd_n = 1'b0; hben = 1'b1;
      #1;
      chk("R7 folded high byte", int'(data_out), (hi << 8) | hi);
      repeat (6) @(negedge clk);
      chk("R1 hben read no start", int'(busy_n), 1);
      hben = 1'b0; #1;
      chk("R6 full word after hben drop", int'(data_out), code);
      cs_n = 1'b1; rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 no start after hben read", int'(busy_n), 1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule